// File: doc/BRIEF.md
# Attention Interrupt Mask Controller

This block owns the two-bit interrupt mask of a host/management-controller message interface and drives the level-sensitive interrupt line toward the host. It keeps an enable bit and a pending bit. It watches the two attention flags that the surrounding logic holds: "response attention" (a reply is waiting for the host) and "event attention" (the controller has an asynchronous event for host software). From these flags, and from a few event pulses, it decides when the host is interrupted and when that interrupt is withdrawn.

The host reads and writes the mask through a byte-wide register port. An edge of the enable bit, not only its level, can raise or drop the interrupt. A response-ready pulse and an event-attention request (assert or deassert) can also set or clear pending. Each of these is qualified by the other attention source and by a system-wide interrupt enable. A reset request with a cold/warm qualifier clears the mask on a cold reset and leaves it alone on a warm one. Whether a physical interrupt line exists at all is chosen at elaboration time.

Top module: `atn_irq_mask`

## Requirements
- R1: The readback `rd_data` carries enable in bit 0 and pending in bit 1. Bits `DATA_W-1:2` always read 0, and writing them has no effect. After `rst_n` both bits are 0.
- R2: With `LINE_USED`=1, `irq` equals the pending bit at all times.
- R3: A write that takes enable from 0 to 1 sets pending on the same clock edge if `b2h_atn` or `sms_atn` is 1. With both flags 0 only enable is set. A write that keeps bit 0 at its current value leaves enable unchanged.
- R4: A write that takes enable from 1 to 0 clears pending together with enable.
- R5: A write with bit 1 = 1 clears pending if pending is set after that write's enable handling. A write with bit 1 = 0 does not clear pending.
- R6: A `rsp_ready` pulse sets pending only when `LINE_USED`=1, `glob_en`=1 and enable=1.
- R7: An event-attention request (`sms_req` with `sms_val`=1) that changes the flag sets pending only when `sms_irq`=1, `LINE_USED`=1, `glob_en`=1, `b2h_atn`=0 and enable=1.
- R8: An event-attention request with `sms_val`=0 that changes the flag clears pending only when `b2h_atn`=0.
- R9: An event-attention request whose `sms_val` equals the current `sms_atn` level has no effect.
- R10: `rst_evt` with `rst_cold`=1 clears enable and pending and wins over every other input in that cycle. `rst_evt` with `rst_cold`=0 changes nothing.
- R11: Pending is never set while enable is 0.
- R12: With `LINE_USED`=0, `irq` stays 0, and neither a response-ready pulse nor an event-attention request sets pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wr_en | input | 1 | Mask register write strobe |
| wr_data | input | DATA_W | Mask register write data |
| b2h_atn | input | 1 | Current response-attention flag |
| sms_atn | input | 1 | Current event-attention flag |
| rsp_ready | input | 1 | Pulse: a response has been placed for the host |
| sms_req | input | 1 | Pulse: request to change the event-attention flag |
| sms_val | input | 1 | Requested event-attention level |
| sms_irq | input | 1 | The assert request may interrupt the host |
| glob_en | input | 1 | System-wide interrupt enable |
| rst_evt | input | 1 | Pulse: interface reset request |
| rst_cold | input | 1 | Qualifies `rst_evt` as a cold reset |
| irq | output | 1 | Level interrupt toward the host |
| rd_data | output | DATA_W | Mask register readback |

## Verification
Enable and pending are registered, and both show on `rd_data` one edge after the stimulus. A wrong next-state decision is therefore visible on the readback at the first sample after the offending cycle, and `irq` shows the same error in that sample when a line is in use. A wrong gating term usually shows as a pending bit that appears with enable clear, or that survives an enable fall, so the pending-implies-enable invariant catches it within one cycle. Ignored stimuli, namely repeated attention levels, warm resets and upper data bits, are judged by reading the full mask right after the stimulus.

// File: rtl/atn_irq_mask_pkg.sv
package atn_irq_mask_pkg;
   localparam int unsigned EN_BIT   = 0;
   localparam int unsigned PEND_BIT = 1;
   localparam int unsigned MASK_W   = 2;

   typedef struct packed {
      logic pend;
      logic en;
   } mask_st_t;

   localparam mask_st_t MASK_CLEAR = '{pend: 1'b0, en: 1'b0};
endpackage

// File: rtl/atn_irq_mask_wr.sv
module atn_irq_mask_wr
   import atn_irq_mask_pkg::*;
(
   input  mask_st_t          st_i,
   input  logic              wr_en,
   input  logic [MASK_W-1:0] wr_bits,
   input  logic              b2h_atn,
   input  logic              sms_atn,
   output mask_st_t          st_o
);
   logic new_en;
   logic any_atn;

   assign new_en  = wr_bits[EN_BIT];
   assign any_atn = b2h_atn | sms_atn;

   always_comb begin
      st_o = st_i;
      if (wr_en) begin
         if (new_en != st_i.en) begin
            if (new_en) begin
               // rising enable: raise at once if anything is waiting
               if (any_atn) st_o.pend = 1'b1;
               st_o.en = 1'b1;
            end else begin
               st_o.pend = 1'b0;
               st_o.en   = 1'b0;
            end
         end
         // acknowledge after enable handling
         if (wr_bits[PEND_BIT] && st_o.pend) st_o.pend = 1'b0;
      end
   end
endmodule

// File: rtl/atn_irq_mask_evt.sv
module atn_irq_mask_evt
   import atn_irq_mask_pkg::*;
#(
   parameter bit LINE_USED = 1'b1
) (
   input  mask_st_t st_i,
   input  logic     rsp_ready,
   input  logic     sms_req,
   input  logic     sms_val,
   input  logic     sms_irq,
   input  logic     sms_atn,
   input  logic     b2h_atn,
   input  logic     glob_en,
   output mask_st_t st_o
);
   logic can_raise;
   logic sms_change;

   assign can_raise  = LINE_USED && glob_en && st_i.en;
   assign sms_change = sms_req && (sms_val != sms_atn);

   always_comb begin
      st_o = st_i;
      if (rsp_ready && can_raise && !st_i.pend) st_o.pend = 1'b1;
      if (sms_change) begin
         if (sms_val) begin
            if (sms_irq && can_raise && !b2h_atn) st_o.pend = 1'b1;
         end else begin
            if (!b2h_atn) st_o.pend = 1'b0;
         end
      end
   end
endmodule

// File: rtl/atn_irq_mask_out.sv
module atn_irq_mask_out
   import atn_irq_mask_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter bit          LINE_USED = 1'b1
) (
   input  mask_st_t          st_i,
   output logic              irq,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned PAD_W = DATA_W - MASK_W;

   always_comb begin
      rd_data           = '0;
      rd_data[EN_BIT]   = st_i.en;
      rd_data[PEND_BIT] = st_i.pend;
   end

   generate
      if (LINE_USED) begin : g_line
         assign irq = st_i.pend;
      end else begin : g_noline
         assign irq = 1'b0;
      end
      if (PAD_W > 64) begin : g_wide
         $error("atn_irq_mask_out: DATA_W unreasonably wide");
      end
   endgenerate
endmodule

// File: rtl/atn_irq_mask.sv
module atn_irq_mask
   import atn_irq_mask_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter bit          LINE_USED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              b2h_atn,
   input  logic              sms_atn,
   input  logic              rsp_ready,
   input  logic              sms_req,
   input  logic              sms_val,
   input  logic              sms_irq,
   input  logic              glob_en,
   input  logic              rst_evt,
   input  logic              rst_cold,
   output logic              irq,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (DATA_W < MASK_W) begin : g_bad_w
         $error("atn_irq_mask: DATA_W must hold the two mask bits");
      end
   endgenerate

   mask_st_t st_q, st_wr, st_nx;
   logic     cold_hit;
   logic     unused_hi_bits;

   assign unused_hi_bits = ^wr_data[DATA_W-1:MASK_W];
   assign cold_hit       = rst_evt && rst_cold;

   atn_irq_mask_wr u_wr (
      .st_i    (st_q),
      .wr_en   (wr_en),
      .wr_bits (wr_data[MASK_W-1:0]),
      .b2h_atn (b2h_atn),
      .sms_atn (sms_atn),
      .st_o    (st_wr)
   );

   atn_irq_mask_evt #(.LINE_USED(LINE_USED)) u_evt (
      .st_i      (st_wr),
      .rsp_ready (rsp_ready),
      .sms_req   (sms_req),
      .sms_val   (sms_val),
      .sms_irq   (sms_irq),
      .sms_atn   (sms_atn),
      .b2h_atn   (b2h_atn),
      .glob_en   (glob_en),
      .st_o      (st_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || cold_hit) st_q <= MASK_CLEAR;
      else                    st_q <= st_nx;
   end

   atn_irq_mask_out #(.DATA_W(DATA_W), .LINE_USED(LINE_USED)) u_out (
      .st_i    (st_q),
      .irq     (irq),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/atn_irq_mask_chk.sv
module atn_irq_mask_chk #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          LINE_USED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              b2h_atn,
   input logic              sms_atn,
   input logic              rsp_ready,
   input logic              sms_req,
   input logic              sms_val,
   input logic              rst_evt,
   input logic              rst_cold,
   input logic              irq,
   input logic [DATA_W-1:0] rd_data
);
   AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[1] |-> rd_data[0]); // R11

   AST_HI_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:2] == '0); // R1

   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (LINE_USED && rd_data[1])); // R2

   AST_COLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_evt && rst_cold) |=> rd_data[1:0] == 2'b00); // R10

   AST_WARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_evt && !rst_cold && !wr_en && !rsp_ready && !sms_req) |=> $stable(rd_data)); // R10

   AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[0] && rd_data[0] && !(rst_evt && rst_cold)) |=> !rd_data[1]); // R4

   AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0] && !wr_data[1] && !rd_data[0] && (b2h_atn || sms_atn)
       && !sms_req && !(rst_evt && rst_cold)) |=> rd_data[1]); // R3

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[1] && !rsp_ready && !sms_req) |=> !rd_data[1]); // R5

   AST_SAME_LEVEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (sms_req && (sms_val == sms_atn) && !wr_en && !rsp_ready && !rst_evt) |=> $stable(rd_data)); // R9
endmodule

bind atn_irq_mask atn_irq_mask_chk #(.DATA_W(DATA_W), .LINE_USED(LINE_USED)) u_chk (.*);

// File: tb/atn_irq_mask_bench.sv
module atn_irq_mask_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         b2h_atn = 1'b0, sms_atn = 1'b0;
   logic         rsp_ready = 1'b0, sms_req = 1'b0, sms_val = 1'b0, sms_irq = 1'b0;
   logic         glob_en = 1'b1, rst_evt = 1'b0, rst_cold = 1'b0;
   logic         irq, nl_irq;
   logic [W-1:0] rd_data, nl_rd;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   atn_irq_mask #(.DATA_W(W), .LINE_USED(1'b1)) u_atn_irq_mask (
      .clk, .rst_n, .wr_en, .wr_data, .b2h_atn, .sms_atn, .rsp_ready,
      .sms_req, .sms_val, .sms_irq, .glob_en, .rst_evt, .rst_cold,
      .irq(irq), .rd_data(rd_data));

   atn_irq_mask #(.DATA_W(W), .LINE_USED(1'b0)) u_noline (
      .clk, .rst_n, .wr_en, .wr_data, .b2h_atn, .sms_atn, .rsp_ready,
      .sms_req, .sms_val, .sms_irq, .glob_en, .rst_evt, .rst_cold,
      .irq(nl_irq), .rd_data(nl_rd));

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   // one clock: pulses set by caller are applied on this edge, then cleared
   task automatic step();
      @(posedge clk);
      #1;
      wr_en = 1'b0; rsp_ready = 1'b0; sms_req = 1'b0; rst_evt = 1'b0;
   endtask

   task automatic wr(input logic [W-1:0] d);
      wr_en = 1'b1; wr_data = d; step();
   endtask

   task automatic rsp();
      rsp_ready = 1'b1; step();
   endtask

   task automatic sms(input logic v, input logic i);
      sms_req = 1'b1; sms_val = v; sms_irq = i; step();
   endtask

   task automatic t_reset();
      chk("R1 reset mask", rd_data, 8'h00);
      chk("R2 reset irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_upper_bits();
      wr(8'hFC); chk("R1 upper bits ignored", rd_data, 8'h00);
      wr(8'hFD); chk("R1 enable only", rd_data, 8'h01);
      wr(8'h01); chk("R3 same bit0 keeps enable", rd_data, 8'h01);
      wr(8'h00); chk("R1 disable", rd_data, 8'h00);
   endtask

   task automatic t_enable_edges();
      b2h_atn = 1'b1;
      wr(8'h01); chk("R3 rise with response attention", rd_data, 8'h03);
      chk("R2 irq follows pending", {7'd0, irq}, 8'h01);
      wr(8'h00); chk("R4 fall clears pending", rd_data, 8'h00);
      chk("R2 irq drops", {7'd0, irq}, 8'h00);
      b2h_atn = 1'b0; sms_atn = 1'b1;
      wr(8'h01); chk("R3 rise with event attention", rd_data, 8'h03);
      wr(8'h00);
      sms_atn = 1'b0;
      wr(8'h01); chk("R3 rise without attention", rd_data, 8'h01);
   endtask

   task automatic t_ack();
      rsp(); chk("R6 response sets pending", rd_data, 8'h03);
      wr(8'h01); chk("R5 bit1=0 keeps pending", rd_data, 8'h03);
      wr(8'h03); chk("R5 ack clears pending", rd_data, 8'h01);
      wr(8'h03); chk("R5 ack when idle", rd_data, 8'h01);
      wr(8'h00); b2h_atn = 1'b1;
      wr(8'h03); chk("R5 rise then ack in one write", rd_data, 8'h01);
      b2h_atn = 1'b0;
   endtask

   task automatic t_rsp_gate();
      glob_en = 1'b0;
      rsp(); chk("R6 global enable off", rd_data, 8'h01);
      glob_en = 1'b1;
      wr(8'h00);
      rsp(); chk("R6 mask enable off", rd_data, 8'h00);
      wr(8'h01);
   endtask

   task automatic t_sms();
      sms(1'b1, 1'b1); chk("R7 event attention raises", rd_data, 8'h03);
      sms_atn = 1'b1;
      sms(1'b0, 1'b0); chk("R8 event deassert clears", rd_data, 8'h01);
      sms_atn = 1'b0;
      sms(1'b1, 1'b0); chk("R7 no interrupt request", rd_data, 8'h01);
      b2h_atn = 1'b1;
      sms(1'b1, 1'b1); chk("R7 blocked by response attention", rd_data, 8'h01);
      rsp(); sms_atn = 1'b1;
      sms(1'b0, 1'b0); chk("R8 deassert kept by response attention", rd_data, 8'h03);
      wr(8'h03); b2h_atn = 1'b0;
   endtask

   task automatic t_repeat();
      sms(1'b1, 1'b1); chk("R9 repeated assert ignored", rd_data, 8'h01);
      rsp(); sms_atn = 1'b0;
      sms(1'b0, 1'b0); chk("R9 repeated deassert ignored", rd_data, 8'h03);
   endtask

   task automatic t_resets();
      rst_evt = 1'b1; rst_cold = 1'b0; step();
      chk("R10 warm reset holds", rd_data, 8'h03);
      rst_evt = 1'b1; rst_cold = 1'b1; step();
      chk("R10 cold reset clears", rd_data, 8'h00);
      chk("R10 cold reset irq", {7'd0, irq}, 8'h00);
      wr(8'h01);
      rst_evt = 1'b1; rst_cold = 1'b1; rsp_ready = 1'b1; step();
      chk("R10 cold reset wins", rd_data, 8'h00);
      rst_cold = 1'b0;
   endtask

   task automatic t_noline();
      wr(8'h01);
      rsp(); chk("R12 response without line", nl_rd, 8'h01);
      chk("R6 response with line", rd_data, 8'h03);
      sms(1'b1, 1'b1); chk("R12 event without line", nl_rd, 8'h01);
      sms_atn = 1'b1;
      wr(8'h00); wr(8'h01); chk("R12 rise sets pending", nl_rd, 8'h03);
      chk("R12 irq stays low", {7'd0, nl_irq}, 8'h00);
      sms_atn = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_upper_bits();
      t_enable_edges();
      t_ack();
      t_rsp_gate();
      t_sms();
      t_repeat();
      t_resets();
      t_noline();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule